// File: doc/BRIEF.md
# Composite-Field AES Substitution Unit

This block turns one byte into its AES substitution value, either the forward SubBytes result or the inverse InvSubBytes result. A one-bit direction input selects which. No 256-entry table is stored anywhere. The byte is moved by a linear change of basis into a field of degree two over GF(2^4). There its multiplicative inverse is found through a single inversion in the 4-bit subfield. It is then moved back, and the affine step is applied (forward) or was applied first (inverse).

Up to three register cuts can be placed inside the path to split its delay into shorter pieces. A valid flag and the direction bit travel with each byte through those cuts, so a stream may change direction on any cycle. The unit is meant to be replicated sixteen times in a round datapath, or used once in a byte-serial engine.

Top module: `sbox_tower`

## Requirements
- R1: With `in_inverse` = 0, `out_byte` equals the AES forward substitution of `in_byte`, for all 256 input values.
- R2: With `in_inverse` = 1, `out_byte` equals the AES inverse substitution of `in_byte`, for all 256 input values.
- R3: The two directions undo each other. Feeding a forward result back in inverse mode returns the original byte, and feeding an inverse result back in forward mode also returns the original byte.
- R4: Zero has no inverse and is handled as zero. Forward mode maps 0x00 to 0x63, and inverse mode maps 0x63 to 0x00.
- R5: `out_valid` and `out_byte` appear exactly STAGES clock cycles after the input was sampled (STAGES from 0 to 3; 0 is purely combinational). A cycle with `in_valid` = 0 yields a cycle with `out_valid` = 0.
- R6: Each result uses the direction that was presented with its own input byte, even when the direction changes every cycle in a back-to-back stream.
- R7: While `rst_n` is low, and on the first cycle after it has been low, `out_valid` is 0 (for STAGES > 0).
- R8: In inverse mode, let u be the inverse-affine image of the input, u_i = x_(i+2 mod 8) ^ x_(i+5 mod 8) ^ x_(i+7 mod 8) ^ c_i with c = 0x05. Then the output multiplied by u in GF(2^8) modulo 0x11B is 1, and the output is 0 when u is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the internal cuts |
| rst_n | input | 1 | Synchronous active-low reset of the valid flags and cut contents |
| in_valid | input | 1 | Marks `in_byte` as a real request |
| in_inverse | input | 1 | 0 selects forward substitution, 1 selects inverse substitution |
| in_byte | input | 8 | Byte to substitute |
| out_valid | output | 1 | Marks `out_byte` as a real result |
| out_byte | output | 8 | Substituted byte |

## Verification
With three cuts, forward and inverse requests can sit in neighbouring stages at once. A forward byte may be in the affine output stage while an inverse byte is still in its inverse-affine entry stage. The bench provokes this with back-to-back streams whose direction is drawn at random each cycle, some of them broken by random idle bubbles. Every result is compared against the value for the direction sampled with that byte, never the current one. In the same way, every idle slot must leave `out_valid` low in exactly the cycle the latency rule predicts.

// File: rtl/sbt_pkg.sv
package sbt_pkg;

  localparam int NIB_W  = 4;
  localparam int BYTE_W = 8;

  typedef logic [NIB_W-1:0]  nib_t;
  typedef logic [BYTE_W-1:0] byte_t;

  // Subfield GF(2^4) is built on w^4 + w + 1; the tower on x^2 + x + LAMBDA.
  localparam nib_t  LAMBDA   = 4'hC;
  localparam byte_t FWD_ADD  = 8'h63;
  localparam byte_t BACK_ADD = 8'h05;

  // Product in GF(2^4): carry-less multiply, then fold w^4 = w + 1.
  function automatic nib_t nib_mul(nib_t a, nib_t b);
    logic [6:0] p;
    p = '0;
    for (int i = 0; i < NIB_W; i++)
      if (b[i]) p ^= 7'(a) << i;
    for (int k = 6; k >= NIB_W; k--)
      if (p[k]) p ^= 7'b0010011 << (k - NIB_W);
    return p[3:0];
  endfunction

  function automatic nib_t nib_sq(nib_t a);
    return nib_mul(a, a);
  endfunction

  // Tower element: high nibble is the coefficient of x, low nibble the constant.
  function automatic byte_t tw_mul(byte_t a, byte_t b);
    nib_t hh, ll, mid;
    hh  = nib_mul(a[7:4], b[7:4]);
    ll  = nib_mul(a[3:0], b[3:0]);
    mid = nib_mul(a[7:4] ^ a[3:0], b[7:4] ^ b[3:0]);
    return {mid ^ ll, nib_mul(hh, LAMBDA) ^ ll};
  endfunction

  // Apply an 8x8 GF(2) matrix held as eight 8-bit columns.
  function automatic byte_t lin_map(logic [63:0] cols, byte_t v);
    byte_t r;
    r = '0;
    for (int i = 0; i < BYTE_W; i++)
      if (v[i]) r ^= cols[8*i +: 8];
    return r;
  endfunction

  // Column i of the basis change is beta^i, beta a tower root of 0x11B.
  function automatic logic [63:0] find_to_tower();
    logic [63:0] cols;
    logic [71:0] pw;
    logic        found;
    byte_t       acc;
    cols  = '0;
    pw    = '0;
    found = 1'b0;
    for (int c = 2; c < 256; c++) begin
      if (!found) begin
        pw[7:0] = 8'h01;
        for (int i = 1; i < 9; i++)
          pw[8*i +: 8] = tw_mul(pw[8*(i-1) +: 8], 8'(c));
        acc = pw[71:64] ^ pw[39:32] ^ pw[31:24] ^ pw[15:8] ^ pw[7:0];
        if (acc == 8'h00) begin
          found = 1'b1;
          cols  = pw[63:0];
        end
      end
    end
    return cols;
  endfunction

  // Reverse basis change: preimage of each tower unit vector.
  function automatic logic [63:0] find_from_tower(logic [63:0] fwd);
    logic [63:0] cols;
    cols = '0;
    for (int j = 0; j < BYTE_W; j++)
      for (int a = 0; a < 256; a++)
        if (lin_map(fwd, 8'(a)) == (8'h01 << j)) cols[8*j +: 8] = 8'(a);
    return cols;
  endfunction

  localparam logic [63:0] TO_TOWER   = find_to_tower();
  localparam logic [63:0] FROM_TOWER = find_from_tower(TO_TOWER);

  // Forward affine step, written per output bit.
  function automatic byte_t aff_fwd(byte_t a);
    byte_t b;
    for (int i = 0; i < BYTE_W; i++)
      b[i] = a[i] ^ a[(i+4)%8] ^ a[(i+5)%8] ^ a[(i+6)%8] ^ a[(i+7)%8] ^ FWD_ADD[i];
    return b;
  endfunction

  // Inverse affine step, written per output bit.
  function automatic byte_t aff_back(byte_t a);
    byte_t b;
    for (int i = 0; i < BYTE_W; i++)
      b[i] = a[(i+2)%8] ^ a[(i+5)%8] ^ a[(i+7)%8] ^ BACK_ADD[i];
    return b;
  endfunction

endpackage

// File: rtl/sbt_cut.sv
module sbt_cut #(
  parameter int W  = 8,
  parameter bit EN = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         d_valid,
  input  logic [W-1:0] d_bits,
  output logic         q_valid,
  output logic [W-1:0] q_bits
);

  generate
    if (EN) begin : g_reg
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          q_valid <= 1'b0;
          q_bits  <= '0;
        end else begin
          q_valid <= d_valid;
          q_bits  <= d_bits;
        end
      end
    end else begin : g_wire
      assign q_valid = d_valid;
      assign q_bits  = d_bits;
    end
  endgenerate

endmodule

// File: rtl/sbt_front.sv
module sbt_front
  import sbt_pkg::*;
(
  input  logic  inverse,
  input  byte_t x,
  output nib_t  hi,
  output nib_t  lo,
  output nib_t  delta
);

  byte_t pre;
  byte_t tw;
  nib_t  hi_sq, lo_sq, hi_lo, hi_sq_lam;

  always_comb begin
    pre = inverse ? aff_back(x) : x;
    tw  = lin_map(TO_TOWER, pre);
  end

  assign hi        = tw[7:4];
  assign lo        = tw[3:0];
  assign hi_sq     = nib_sq(hi);
  assign lo_sq     = nib_sq(lo);
  assign hi_lo     = nib_mul(hi, lo);
  assign hi_sq_lam = nib_mul(hi_sq, LAMBDA);
  // Norm of the tower element: the only value that needs a subfield inverse.
  assign delta     = hi_sq_lam ^ hi_lo ^ lo_sq;

  // The two derived basis changes must undo each other.
  always_comb begin
    p_map_roundtrip_r3: assert (lin_map(FROM_TOWER, tw) == pre);
  end

endmodule

// File: rtl/sbt_subinv.sv
module sbt_subinv
  import sbt_pkg::*;
(
  input  logic live,
  input  nib_t d,
  output nib_t d_inv
);

  nib_t d2, d4, d8, d6;

  // d^14 = d^2 * d^4 * d^8; zero maps to zero.
  assign d2    = nib_sq(d);
  assign d4    = nib_sq(d2);
  assign d8    = nib_sq(d4);
  assign d6    = nib_mul(d2, d4);
  assign d_inv = nib_mul(d6, d8);

  always_comb begin
    if (live && (d != '0)) begin
      p_sub_inverse_r8: assert (nib_mul(d, d_inv) == 4'h1);
    end
    if (live && (d == '0)) begin
      p_sub_zero_r8: assert (d_inv == '0);
    end
  end

endmodule

// File: rtl/sbt_back.sv
module sbt_back
  import sbt_pkg::*;
(
  input  logic  live,
  input  logic  inverse,
  input  nib_t  hi,
  input  nib_t  lo,
  input  nib_t  d_inv,
  output byte_t y
);

  nib_t  new_hi, new_lo;
  byte_t inv_tw;
  byte_t plain;

  assign new_hi = nib_mul(hi, d_inv);
  assign new_lo = nib_mul(hi ^ lo, d_inv);
  assign inv_tw = {new_hi, new_lo};
  assign plain  = lin_map(FROM_TOWER, inv_tw);
  assign y      = inverse ? plain : aff_fwd(plain);

  // Element carried from the front times its rebuilt inverse must be one.
  always_comb begin
    if (live && ({hi, lo} != '0)) begin
      p_tower_inverse_r8: assert (tw_mul({hi, lo}, inv_tw) == 8'h01);
    end
    if (live && ({hi, lo} == '0)) begin
      p_tower_zero_r4: assert (inv_tw == '0);
    end
  end

endmodule

// File: rtl/sbox_tower.sv
module sbox_tower
  import sbt_pkg::*;
#(
  parameter int unsigned STAGES = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic       in_inverse,
  input  logic [7:0] in_byte,
  output logic       out_valid,
  output logic [7:0] out_byte
);

  // Cut placement: one cut splits after the subfield inverse, a second
  // one before it, a third registers the final byte.
  localparam bit CUT_MID = (STAGES >= 1);
  localparam bit CUT_PRE = (STAGES >= 2);
  localparam bit CUT_OUT = (STAGES >= 3);
  localparam int W_A     = 1 + 3*NIB_W;
  localparam int W_B     = 1 + 3*NIB_W;

  nib_t f_hi, f_lo, f_delta;
  logic           s1_valid;
  logic [W_A-1:0] s1_bits;
  logic           s1_inv;
  nib_t           s1_hi, s1_lo, s1_delta, s1_dinv;
  logic           s2_valid;
  logic [W_B-1:0] s2_bits;
  logic           s2_inv;
  nib_t           s2_hi, s2_lo, s2_dinv;
  byte_t          s2_y;

  sbt_front u_front (
    .inverse (in_inverse),
    .x       (in_byte),
    .hi      (f_hi),
    .lo      (f_lo),
    .delta   (f_delta)
  );

  sbt_cut #(.W(W_A), .EN(CUT_PRE)) u_cut_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_valid (in_valid),
    .d_bits  ({in_inverse, f_hi, f_lo, f_delta}),
    .q_valid (s1_valid),
    .q_bits  (s1_bits)
  );

  assign {s1_inv, s1_hi, s1_lo, s1_delta} = s1_bits;

  sbt_subinv u_subinv (
    .live  (s1_valid & rst_n),
    .d     (s1_delta),
    .d_inv (s1_dinv)
  );

  sbt_cut #(.W(W_B), .EN(CUT_MID)) u_cut_mid (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_valid (s1_valid),
    .d_bits  ({s1_inv, s1_hi, s1_lo, s1_dinv}),
    .q_valid (s2_valid),
    .q_bits  (s2_bits)
  );

  assign {s2_inv, s2_hi, s2_lo, s2_dinv} = s2_bits;

  sbt_back u_back (
    .live    (s2_valid & rst_n),
    .inverse (s2_inv),
    .hi      (s2_hi),
    .lo      (s2_lo),
    .d_inv   (s2_dinv),
    .y       (s2_y)
  );

  sbt_cut #(.W(BYTE_W), .EN(CUT_OUT)) u_cut_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_valid (s2_valid),
    .d_bits  (s2_y),
    .q_valid (out_valid),
    .q_bits  (out_byte)
  );

  generate
    if (STAGES > 0) begin : g_chk
      localparam logic [1:0] STG = 2'(STAGES);
      logic [1:0] warm_cnt;
      logic       warm;

      always_ff @(posedge clk) begin
        if (!rst_n)                warm_cnt <= 2'd0;
        else if (warm_cnt != 2'd3) warm_cnt <= warm_cnt + 2'd1;
      end
      assign warm = (warm_cnt >= STG);

      p_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
        warm |-> (out_valid == $past(in_valid, STAGES)));

      p_zero_fwd_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && $past(in_valid && !in_inverse && (in_byte == 8'h00), STAGES))
        |-> (out_byte == 8'h63));

      p_zero_back_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && $past(in_valid && in_inverse && (in_byte == 8'h63), STAGES))
        |-> (out_byte == 8'h00));

      p_reset_quiet_r7: assert property (@(posedge clk)
        !rst_n |=> !out_valid);
    end
  endgenerate

endmodule

// File: tb/sbox_tower_bench.sv
`timescale 1ns/1ps
module sbox_tower_bench;

  localparam int LAT = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_inverse = 1'b0;
  logic [7:0] in_byte = 8'h00;
  logic       out_valid;
  logic [7:0] out_byte;

  always #4 clk = ~clk;

  sbox_tower #(.STAGES(LAT)) u_sbox_tower (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_inverse (in_inverse),
    .in_byte    (in_byte),
    .out_valid  (out_valid),
    .out_byte   (out_byte)
  );

  int n_cmp = 0;
  int n_bad = 0;
  logic done = 1'b0;
  logic [7:0] ref_f [256];
  logic [7:0] ref_i [256];
  logic [7:0] obs_f [256];
  logic [7:0] obs_i [256];

  typedef struct {
    logic       v;
    logic       m;
    logic [7:0] x;
    logic [7:0] e;
    int         kind;   // 0 compare, 1 store forward, 2 store inverse + R8
    string      tag;
  } item_t;
  item_t q[$];

  // GF(2^8) modulo 0x11B, shift-and-add.
  function automatic logic [7:0] b_gmul(logic [7:0] a, logic [7:0] b);
    logic [7:0] r = 8'h00;
    logic [7:0] t = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) r = r ^ t;
      t = t[7] ? ((t << 1) ^ 8'h1B) : (t << 1);
    end
    return r;
  endfunction

  function automatic logic [7:0] b_ginv(logic [7:0] a);
    logic [7:0] r = 8'h01;
    if (a == 8'h00) return 8'h00;
    for (int i = 0; i < 254; i++) r = b_gmul(r, a);
    return r;
  endfunction

  function automatic logic [7:0] b_rotl(logic [7:0] a, int k);
    return 8'((a << k) | (a >> (8 - k)));
  endfunction

  function automatic logic [7:0] b_affine(logic [7:0] a);
    return a ^ b_rotl(a, 1) ^ b_rotl(a, 2) ^ b_rotl(a, 3) ^ b_rotl(a, 4) ^ 8'h63;
  endfunction

  function automatic logic [7:0] b_unaffine(logic [7:0] a);
    return b_rotl(a, 1) ^ b_rotl(a, 3) ^ b_rotl(a, 6) ^ 8'h05;
  endfunction

  task automatic cmp(string tag, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic retire();
    item_t it;
    logic [7:0] u;
    if (q.size() == LAT) begin
      it = q.pop_front();
      cmp(it.tag, "out_valid", int'(out_valid), int'(it.v));
      if (it.v) begin
        cmp(it.tag, "out_byte", int'(out_byte), int'(it.e));
        if (it.kind == 1) obs_f[it.x] = out_byte;
        if (it.kind == 2) begin
          obs_i[it.x] = out_byte;
          u = b_unaffine(it.x);
          if (u == 8'h00) cmp("R8", "zero image", int'(out_byte), 0);
          else cmp("R8", "product", int'(b_gmul(u, out_byte)), 1);
        end
      end
    end
  endtask

  task automatic step(logic v, logic m, logic [7:0] x, logic [7:0] e, int kind, string tag);
    item_t it;
    @(negedge clk);
    retire();
    in_valid   = v;
    in_inverse = m;
    in_byte    = x;
    it.v = v; it.m = m; it.x = x; it.e = e; it.kind = kind; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic flush();
    for (int i = 0; i < LAT + 1; i++) step(1'b0, 1'b0, 8'h00, 8'h00, 0, "R5");
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog R5: actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] x;
    logic m, v;
    int unused_seed;
    unused_seed = $urandom(32'd90210);
    for (int i = 0; i < 256; i++) begin
      ref_f[i] = b_affine(b_ginv(8'(i)));
      ref_i[ref_f[i]] = 8'(i);
    end

    // R7: reset state
    repeat (3) @(negedge clk);
    cmp("R7", "out_valid in reset", int'(out_valid), 0);
    rst_n = 1'b1;

    // R1 / R4: full forward sweep
    for (int i = 0; i < 256; i++)
      step(1'b1, 1'b0, 8'(i), ref_f[i], 1, (i == 0) ? "R4" : "R1");
    // R2 / R4 / R8: full inverse sweep
    for (int i = 0; i < 256; i++)
      step(1'b1, 1'b1, 8'(i), ref_i[i], 2, (i == 8'h63) ? "R4" : "R2");
    flush();

    // R3: feed observed results back through the other direction
    for (int i = 0; i < 256; i++) begin
      step(1'b1, 1'b1, obs_f[i], 8'(i), 0, "R3");
      step(1'b1, 1'b0, obs_i[i], 8'(i), 0, "R3");
    end
    flush();

    // R6: direction changes freely in a back-to-back stream
    for (int k = 0; k < 1500; k++) begin
      m = (k < 64) ? k[0] : 1'($urandom);
      x = (k % 97 == 0) ? 8'h00 : 8'($urandom);
      step(1'b1, m, x, m ? ref_i[x] : ref_f[x], 0, "R6");
    end
    flush();

    // R5: idle bubbles keep their place in the stream
    for (int k = 0; k < 1000; k++) begin
      v = (($urandom % 3) != 0);
      m = 1'($urandom);
      x = 8'($urandom);
      step(v, m, x, m ? ref_i[x] : ref_f[x], 0, "R5");
    end
    flush();

    // R7: reset with requests in flight
    for (int k = 0; k < 4; k++) step(1'b1, 1'b0, 8'(k), ref_f[k], 0, "R7");
    @(negedge clk);
    rst_n = 1'b0;
    in_valid = 1'b0;
    q.delete();
    @(negedge clk);
    cmp("R7", "out_valid after reset", int'(out_valid), 0);
    rst_n = 1'b1;
    for (int k = 0; k < 40; k++) begin
      m = k[1];
      x = 8'($urandom);
      step(1'b1, m, x, m ? ref_i[x] : ref_f[x], 0, "R7");
    end
    flush();

    done = 1'b1;
    summary();
    $finish;
  end

endmodule